// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide host interface of a three-channel interval timer. A host reaches it through a 2-bit address with separate read and write strobes. Addresses 0, 1 and 2 are the per-channel count data ports and address 3 is the control port. Control words set up a channel: they choose how the 16-bit count moves over the 8-bit bus, and they give the counting mode and whether the count is decimal (BCD). Data writes then assemble a new count, which is handed to the channel as a one-cycle load pulse together with the new mode.

Reads return the live count or a frozen snapshot of it. A latch command freezes one channel's count. A read-back command can freeze the count, the status byte, or both, on any subset of the channels in one write. A latched status byte is always returned before any count byte. Each channel has one byte-order pointer, shared by reads and writes, that decides whether the low or the high byte is next. The counting logic itself lives in the channels. This block only receives their live counts and output levels.

Top module: `tmr_regif`

## Requirements
- R1: A control word with bits 7:6 = channel 0..2 and a nonzero access field in bits 5:4 programs that channel. Access 01 moves the low byte only, 10 the high byte only, and 11 the low byte then the high byte. Bits 3:1 give the mode and bit 0 selects BCD. The cycle after the final data byte, `loadStb` pulses for that channel and `chanMode`/`chanBcd` take the new values.
- R2: Mode, BCD flag and count do not change, and no load pulse occurs, until every byte the access field calls for has been written. After only the low byte of an access-11 write, nothing is loaded.
- R3: When the new BCD flag is set, the count presented on `loadCount` is the binary value of the BCD digits written.
- R4: Without a latch, a count read returns the channel's live count. Access 01 gives the low byte, 10 the high byte, and 11 the low byte then the high byte. When the channel is in BCD mode, the count is given as BCD digits.
- R5: A control word with access 00 latches that channel's count. Reads return the frozen value until every byte the access field calls for has been read, and live values after that.
- R6: A count latch request on a channel whose count is already latched and unread is ignored.
- R7: A control word with bits 7:6 = 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count and bit 4 = 0 latches the status of every selected channel.
- R8: A latched status byte is returned by the channel's next read, before any count byte. Its layout is: bit 7 the channel output level, bit 6 null-count, bits 5:4 the access field, bits 3:1 the active mode, bit 0 the active BCD flag.
- R9: Writing a control word sets the channel's null-count flag. Completing the count load clears it.
- R10: Completing a count load discards any pending count or status latch on that channel.
- R11: A status latch request on a channel whose status is already latched and unread is ignored.
- R12: Reading address 3 returns 0xFF. After reset every channel has access field 00, mode 0, binary counting and no load pulse, and data writes are ignored until a control word programs the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0..2 channel data, 3 control |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| rdEn | input | 1 | Read strobe; read side effects apply at the clock edge |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte for the current address (combinational) |
| liveCount | input | 48 | Live binary count of each channel, 16 bits per channel |
| chanOut | input | 3 | Output level of each channel |
| loadStb | output | 3 | One-cycle pulse per channel when a new count is loaded |
| loadCount | output | 48 | Binary count to load, 16 bits per channel |
| chanMode | output | 9 | Active counting mode, 3 bits per channel |
| chanBcd | output | 3 | Active BCD flag per channel |

## Verification
Loads are driven with all three access fields and with BCD both set and clear. These patterns separate byte placement errors from BCD conversion errors, and a check after half of a two-byte load shows whether loading happens too early. Count reads alternate between latched and live sources, with the live count moved between byte reads, so a frozen value can be told apart from a live one. Repeated latch requests show whether a second request is wrongly accepted. Read-back commands select a single channel and then two channels with both count and status requested, which exercises the mask decode and the rule that status comes first. The null-count and latch-discard behaviour is shown by reading the status before and after a load that lands while a count latch is pending.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } accMode_e;

  // Per-channel strobes from the decoder to the channel datapath
  typedef struct packed {
    logic progCtl;
    logic latchCnt;
    logic latchStat;
    logic dataWr;
    logic dataRd;
  } chanStb_t;

  function automatic logic [CNT_W-1:0] bin2bcd(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    r[3:0]   = 4'(v % 16'd10);
    r[7:4]   = 4'((v / 16'd10) % 16'd10);
    r[11:8]  = 4'((v / 16'd100) % 16'd10);
    r[15:12] = 4'((v / 16'd1000) % 16'd10);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] bcd2bin(input logic [CNT_W-1:0] v);
    return 16'(v[3:0]) + 16'(v[7:4]) * 16'd10 +
           16'(v[11:8]) * 16'd100 + 16'(v[15:12]) * 16'd1000;
  endfunction
endpackage

// File: rtl/tmr_regif_ctrl.sv
module tmr_regif_ctrl
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CHAN = 3
) (
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:1] ctlByte,
  output chanStb_t   stb [NUM_CHAN]
);
  logic       ctlHit;
  logic       isReadBack;
  logic [1:0] selCh;
  logic [1:0] accField;

  assign ctlHit     = wrEn && (addr == 2'd3);
  assign selCh      = ctlByte[7:6];
  assign accField   = ctlByte[5:4];
  assign isReadBack = (selCh == 2'd3);

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_dec
    logic chanSel;
    logic rbSel;
    assign chanSel = ctlHit && !isReadBack && (selCh == 2'(i));
    assign rbSel   = ctlHit && isReadBack && ctlByte[i+1];

    assign stb[i].progCtl   = chanSel && (accField != ACC_LATCH);
    assign stb[i].latchCnt  = (chanSel && (accField == ACC_LATCH)) || (rbSel && !ctlByte[5]);
    assign stb[i].latchStat = rbSel && !ctlByte[4];
    assign stb[i].dataWr    = wrEn && (addr == 2'(i));
    assign stb[i].dataRd    = rdEn && !wrEn && (addr == 2'(i));
  end
endmodule

// File: rtl/tmr_regif_chan.sv
module tmr_regif_chan
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStb_t          stb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  liveCount,
  input  logic              outLvl,
  output logic [BYTE_W-1:0] rdByte,
  output logic              loadStb,
  output logic [CNT_W-1:0]  loadCount,
  output logic [MODE_W-1:0] actMode,
  output logic              actBcd
);
  accMode_e          accMode;
  logic [MODE_W-1:0] newMode;
  logic              newBcd;
  logic              nullCnt;
  logic              hiNext;
  logic              cntLat;
  logic              statLat;
  logic [CNT_W-1:0]  latVal;
  logic [BYTE_W-1:0] statVal;
  logic [BYTE_W-1:0] loStage;

  logic [CNT_W-1:0]  cntSel;
  logic [CNT_W-1:0]  cntFmt;
  logic              finNow;
  logic [CNT_W-1:0]  finVal;

  // Read path
  always_comb begin
    cntSel = cntLat ? latVal : liveCount;
    cntFmt = actBcd ? bin2bcd(cntSel) : cntSel;
    rdByte = '0;
    if (statLat) begin
      rdByte = statVal;
    end else begin
      case (accMode)
        ACC_LO:   rdByte = cntFmt[7:0];
        ACC_HI:   rdByte = cntFmt[15:8];
        ACC_WORD: rdByte = hiNext ? cntFmt[15:8] : cntFmt[7:0];
        default:  rdByte = '0;
      endcase
    end
  end

  // Write completion
  always_comb begin
    finNow = 1'b0;
    finVal = '0;
    case (accMode)
      ACC_LO: begin
        finNow = stb.dataWr;
        finVal = {8'h00, wrData};
      end
      ACC_HI: begin
        finNow = stb.dataWr;
        finVal = {wrData, 8'h00};
      end
      ACC_WORD: begin
        finNow = stb.dataWr && hiNext;
        finVal = {wrData, loStage};
      end
      default: begin
        finNow = 1'b0;
        finVal = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode   <= ACC_LATCH;
      newMode   <= '0;
      newBcd    <= 1'b0;
      nullCnt   <= 1'b0;
      hiNext    <= 1'b0;
      cntLat    <= 1'b0;
      statLat   <= 1'b0;
      latVal    <= '0;
      statVal   <= '0;
      loStage   <= '0;
      loadStb   <= 1'b0;
      loadCount <= '0;
      actMode   <= '0;
      actBcd    <= 1'b0;
    end else begin
      loadStb <= 1'b0;

      if (stb.progCtl) begin
        accMode <= accMode_e'(wrData[5:4]);
        newMode <= wrData[3:1];
        newBcd  <= wrData[0];
        nullCnt <= 1'b1;
        hiNext  <= 1'b0;
      end

      if (stb.latchCnt && !cntLat) begin
        latVal <= liveCount;
        cntLat <= 1'b1;
      end

      if (stb.latchStat && !statLat) begin
        statVal <= {outLvl, nullCnt, accMode, actMode, actBcd};
        statLat <= 1'b1;
      end

      if (stb.dataRd) begin
        if (statLat) begin
          statLat <= 1'b0;
        end else begin
          case (accMode)
            ACC_LO, ACC_HI: cntLat <= 1'b0;
            ACC_WORD: begin
              hiNext <= !hiNext;
              if (hiNext) cntLat <= 1'b0;
            end
            default: ;
          endcase
        end
      end

      if (stb.dataWr && accMode == ACC_WORD) begin
        if (!hiNext) loStage <= wrData;
        hiNext <= !hiNext;
      end

      if (finNow) begin
        loadStb   <= 1'b1;
        loadCount <= newBcd ? bcd2bin(finVal) : finVal;
        actMode   <= newMode;
        actBcd    <= newBcd;
        nullCnt   <= 1'b0;
        cntLat    <= 1'b0;
        statLat   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CHAN = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 addr,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [7:0]                 wrData,
  output logic [7:0]                 rdData,
  input  logic [NUM_CHAN*16-1:0]     liveCount,
  input  logic [NUM_CHAN-1:0]        chanOut,
  output logic [NUM_CHAN-1:0]        loadStb,
  output logic [NUM_CHAN*16-1:0]     loadCount,
  output logic [NUM_CHAN*3-1:0]      chanMode,
  output logic [NUM_CHAN-1:0]        chanBcd
);
  chanStb_t          stb    [NUM_CHAN];
  logic [BYTE_W-1:0] rdByte [NUM_CHAN];

  tmr_regif_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .ctlByte (wrData[7:1]),
    .stb     (stb)
  );

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    tmr_regif_chan u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb[i]),
      .wrData    (wrData),
      .liveCount (liveCount[i*CNT_W +: CNT_W]),
      .outLvl    (chanOut[i]),
      .rdByte    (rdByte[i]),
      .loadStb   (loadStb[i]),
      .loadCount (loadCount[i*CNT_W +: CNT_W]),
      .actMode   (chanMode[i*MODE_W +: MODE_W]),
      .actBcd    (chanBcd[i])
    );
  end

  always_comb begin
    rdData = 8'hFF;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (addr == 2'(i)) rdData = rdByte[i];
    end
  end
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
  parameter int NUM_CHAN = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            addr,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [7:0]            rdData,
  input logic [NUM_CHAN-1:0]   loadStb,
  input logic [NUM_CHAN*3-1:0] chanMode,
  input logic [NUM_CHAN-1:0]   chanBcd
);
  AST_CTL_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd3) |-> rdData == 8'hFF); // R12

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStb)); // R1

  AST_LOAD_NEEDS_DATA_WR: assert property (@(posedge clk) disable iff (!rstN)
    (|loadStb) |-> ($past(wrEn) && $past(addr) != 2'd3)); // R2

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(|loadStb) |-> $stable(chanMode)); // R2

  AST_BCD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(|loadStb) |-> $stable(chanBcd)); // R3

  AST_NO_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> loadStb == '0); // R12
endmodule

bind tmr_regif tmr_regif_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .loadStb  (loadStb),
  .chanMode (chanMode),
  .chanBcd  (chanBcd)
);

// File: tb/tmr_regif_bench.sv
module tmr_regif_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [47:0] liveCount = '0;
  logic [2:0]  chanOut = '0;
  logic [2:0]  loadStb;
  logic [47:0] loadCount;
  logic [8:0]  chanMode;
  logic [2:0]  chanBcd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_regif u_tmr_regif (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .liveCount(liveCount), .chanOut(chanOut),
    .loadStb(loadStb), .loadCount(loadCount), .chanMode(chanMode), .chanBcd(chanBcd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCount(input int ch, input logic [15:0] v);
    liveCount[ch*16 +: 16] = v;
  endtask

  task automatic testReset();
    logic [7:0] b;
    check("R12 loadStb after reset", 32'(loadStb), 32'h0);
    check("R12 mode after reset", 32'(chanMode), 32'h0);
    check("R12 bcd after reset", 32'(chanBcd), 32'h0);
    busRead(2'd3, b);
    check("R12 control read", 32'(b), 32'hFF);
    busWrite(2'd0, 8'h55);
    check("R12 unprogrammed data write", 32'(loadStb), 32'h0);
  endtask

  task automatic testLoads();
    busWrite(2'd3, 8'h34);            // ch0, word, mode 2, binary
    check("R9 no load on control", 32'(loadStb), 32'h0);
    busWrite(2'd0, 8'h34);
    check("R2 no load after low byte", 32'(loadStb), 32'h0);
    check("R2 mode unchanged", 32'(chanMode[2:0]), 32'h0);
    busWrite(2'd0, 8'h12);
    check("R1 word load strobe", 32'(loadStb), 32'h1);
    check("R1 word load value", 32'(loadCount[15:0]), 32'h1234);
    check("R1 mode ch0", 32'(chanMode[2:0]), 32'h2);
    busWrite(2'd3, 8'h50);            // ch1, low only, mode 0
    busWrite(2'd1, 8'hAB);
    check("R1 low-only load", 32'(loadCount[31:16]), 32'h00AB);
    busWrite(2'd3, 8'hA6);            // ch2, high only, mode 3
    busWrite(2'd2, 8'h56);
    check("R1 high-only strobe", 32'(loadStb), 32'h4);
    check("R1 high-only load", 32'(loadCount[47:32]), 32'h5600);
    check("R1 mode ch2", 32'(chanMode[8:6]), 32'h3);
  endtask

  task automatic testBcdLoad();
    busWrite(2'd3, 8'h71);            // ch1, word, mode 0, BCD
    busWrite(2'd1, 8'h34);
    busWrite(2'd1, 8'h12);
    check("R3 BCD load converted", 32'(loadCount[31:16]), 32'h04D2);
    check("R3 BCD flag active", 32'(chanBcd), 32'h2);
  endtask

  task automatic testLiveReads();
    logic [7:0] b;
    setCount(0, 16'hBEEF);
    busRead(2'd0, b); check("R4 live low", 32'(b), 32'hEF);
    busRead(2'd0, b); check("R4 live high", 32'(b), 32'hBE);
    setCount(1, 16'd1234);
    busRead(2'd1, b); check("R4 BCD low", 32'(b), 32'h34);
    busRead(2'd1, b); check("R4 BCD high", 32'(b), 32'h12);
    setCount(2, 16'h5678);
    busRead(2'd2, b); check("R4 high-only read", 32'(b), 32'h56);
  endtask

  task automatic testLatch();
    logic [7:0] b;
    setCount(0, 16'h1111);
    busWrite(2'd3, 8'h00);
    setCount(0, 16'h2222);
    busWrite(2'd3, 8'h00);            // ignored, still latched
    busRead(2'd0, b); check("R6 second latch ignored", 32'(b), 32'h11);
    setCount(0, 16'h3333);
    busRead(2'd0, b); check("R5 latched high", 32'(b), 32'h11);
    busRead(2'd0, b); check("R5 released low", 32'(b), 32'h33);
    busRead(2'd0, b); check("R5 released high", 32'(b), 32'h33);
  endtask

  task automatic testReadBack();
    logic [7:0] b;
    chanOut = 3'b100;
    busWrite(2'd3, 8'hE8);            // status only, ch2
    chanOut = 3'b000;
    busWrite(2'd3, 8'hE8);            // ignored, still latched
    busRead(2'd2, b); check("R8 status byte ch2", 32'(b), 32'hA6);
    check("R11 second status latch ignored", 32'(b), 32'hA6);
    busRead(2'd2, b); check("R8 count after status", 32'(b), 32'h56);
    setCount(0, 16'h4455);
    setCount(1, 16'd5678);
    busWrite(2'd3, 8'hC6);            // count and status, ch0 and ch1
    setCount(0, 16'h0000);
    setCount(1, 16'h0000);
    busRead(2'd0, b); check("R7 status ch0", 32'(b), 32'h34);
    busRead(2'd0, b); check("R7 latched low ch0", 32'(b), 32'h55);
    busRead(2'd0, b); check("R7 latched high ch0", 32'(b), 32'h44);
    busRead(2'd1, b); check("R7 status ch1", 32'(b), 32'h31);
    busRead(2'd1, b); check("R7 latched BCD low ch1", 32'(b), 32'h78);
    busRead(2'd1, b); check("R7 latched BCD high ch1", 32'(b), 32'h56);
  endtask

  task automatic testNullAndClear();
    logic [7:0] b;
    busWrite(2'd3, 8'h36);            // ch0, word, mode 3
    busWrite(2'd3, 8'hE2);            // status ch0
    busRead(2'd0, b); check("R9 null-count set", 32'(b), 32'h74);
    setCount(0, 16'h9999);
    busWrite(2'd3, 8'h00);            // latch count
    busWrite(2'd3, 8'hE2);            // latch status too
    busWrite(2'd0, 8'h10);
    busWrite(2'd0, 8'h00);
    check("R1 reload value", 32'(loadCount[15:0]), 32'h0010);
    setCount(0, 16'h0BCD);
    busRead(2'd0, b); check("R10 latches discarded low", 32'(b), 32'hCD);
    busRead(2'd0, b); check("R10 latches discarded high", 32'(b), 32'h0B);
    busWrite(2'd3, 8'hE2);
    busRead(2'd0, b); check("R9 null-count cleared", 32'(b), 32'h36);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoads();
    testBcdLoad();
    testLiveReads();
    testLatch();
    testReadBack();
    testNullAndClear();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule